// File: doc/BRIEF.md
# Scan and Conversion Sequencer

This block paces a multichannel acquisition. An arm pulse starts a scan-interval counter. Each time that counter expires it requests a start-of-scan. An accepted start-of-scan starts a sample-interval counter, which issues one active-low convert pulse per channel of the scan. A scan-clock pulse follows each convert pulse. The start-of-scan request can come from the internal counter or from an external scan pulse input.

A scan tracker holds the number of post-trigger scans. In pretrigger mode it does not count until a reference trigger arrives, so any number of scans may run before that trigger. After it, a fixed number of scans is taken, and a done pulse then marks the last conversion. A stop input aborts the run at once. Two gate inputs, one for hardware and one for software, can hold scans off. Both interval counters advance only on a timebase tick.

Top module: `acq_sequencer`

## Requirements
- R1: A pulse on `arm_i` while idle loads the scan-interval counter with `scan_ivl_i` (S). With the internal source, the first `sos_o` pulse appears S+1 ticks after the arm cycle. `arm_i` has no effect while a run is active.
- R2: With the internal source, start-of-scan requests repeat every S+1 ticks for as long as the run is active.
- R3: Each accepted scan issues `last_chan_i`+1 conversions. The first comes one tick after `sos_o`, and the rest follow at intervals of `samp_ivl_i`+1 ticks. `convert_n_o` is low for exactly one cycle per conversion and high otherwise.
- R4: `scan_clk_o` is high for one cycle, in the cycle right after each cycle in which `convert_n_o` is low.
- R5: A scan request is dropped when the run is idle or a scan is already in progress. When `src_ext_i`=1, requests come from `ext_scan_i`, and `sos_o` follows that pulse by one cycle.
- R6: A scan request is dropped while `gate_i`=0 or `hold_i`=1. Later requests proceed normally.
- R7: With `pretrig_i`=0, the run ends after max(`post_scans_i`,1) scans. `done_o` is high for one cycle, in the same cycle as the final `convert_n_o` low, and the block is then idle.
- R8: With `pretrig_i`=1, scans that end before `ref_trig_i` are not counted. After `ref_trig_i`, max(`post_scans_i`,1) further scans complete, and then the run ends as in R7.
- R9: `stop_i` ends the run at once. From the next cycle there is no `sos_o`, no `convert_n_o` low and no `done_o`.
- R10: Both interval counters hold their value in cycles where `tick_i`=0. A run whose ticks are withheld for D cycles right after arm produces the same pulses, delayed by D cycles.
- R11: After reset, `convert_n_o`=1 and `sos_o`, `scan_clk_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start trigger pulse |
| ref_trig_i | input | 1 | Reference (second) trigger pulse for pretrigger mode |
| stop_i | input | 1 | Software stop, aborts the run |
| gate_i | input | 1 | Hardware scan gate, 1 allows scans |
| hold_i | input | 1 | Software hold, 1 blocks scans |
| src_ext_i | input | 1 | 1 selects `ext_scan_i` as the scan request source |
| ext_scan_i | input | 1 | External scan request pulse |
| tick_i | input | 1 | Timebase enable for both interval counters |
| pretrig_i | input | 1 | 1 selects pretrigger mode |
| scan_ivl_i | input | IVL_W | Scan interval minus one, in ticks |
| samp_ivl_i | input | IVL_W | Sample interval minus one, in ticks |
| last_chan_i | input | CH_W | Channels per scan minus one |
| post_scans_i | input | SCAN_W | Post-trigger scan count |
| sos_o | output | 1 | Start-of-scan pulse |
| convert_n_o | output | 1 | Active-low convert pulse |
| scan_clk_o | output | 1 | Scan clock pulse, one cycle after convert |
| done_o | output | 1 | Final-conversion pulse |

## Verification
The case that is hardest to reach from the ports is a reference trigger that lands between two scans of a pretriggered run. It must come after the last conversion of one scan and before the next scan request, so that the count of further scans is exact. The stimulus computes both cycles in closed form from the interval settings and drives the reference trigger there. A similar computed window drops the gate and raises the hold around a chosen request cycle, so that one scan slot disappears and the following ones keep their positions. An external request sent while a scan is still converting checks that requests are dropped while the block is busy.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic {
        SRC_TIMER = 1'b0,
        SRC_EXT   = 1'b1
    } scan_src_e;

    typedef struct packed {
        logic sos;
        logic conv_n;
        logic sclk;
        logic done;
    } pulse_t;

endpackage

// File: rtl/ivl_counter.sv
module ivl_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] reload_i,
    output logic         tc_o
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tc_o  = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && tick_i) begin
            if (cnt_q == ZERO) begin
                tc_o  = 1'b1;
                cnt_d = reload_i;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    // R10: no tick, no load -> count frozen
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/scan_tracker.sv
module scan_tracker #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         pretrig_i,
    input  logic [W-1:0] post_i,
    input  logic         ref_i,
    input  logic         scan_end_i,
    output logic         last_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic         counting;
        logic [W-1:0] rem;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.counting = !pretrig_i;
            st_d.rem      = post_i;
        end else begin
            if (ref_i)
                st_d.counting = 1'b1;
            if (scan_end_i && st_q.counting && st_q.rem != '0)
                st_d.rem = st_q.rem - 1'b1;
        end
        last_o = st_q.counting && (st_q.rem <= ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: before the reference trigger the remaining count never moves
    p_no_count_pretrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.counting && !load_i) |=> $stable(st_q.rem));

endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
    import acq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sos_fire_i,
    input  logic conv_fire_i,
    input  logic final_fire_i,
    output logic sos_o,
    output logic convert_n_o,
    output logic scan_clk_o,
    output logic done_o
);
    localparam pulse_t IDLE = '{sos: 1'b0, conv_n: 1'b1, sclk: 1'b0, done: 1'b0};

    pulse_t pl_d, pl_q;

    always_comb begin
        pl_d.sos    = sos_fire_i;
        pl_d.conv_n = !conv_fire_i;
        pl_d.sclk   = !pl_q.conv_n;
        pl_d.done   = final_fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= IDLE;
        else        pl_q <= pl_d;
    end

    assign sos_o       = pl_q.sos;
    assign convert_n_o = pl_q.conv_n;
    assign scan_clk_o  = pl_q.sclk;
    assign done_o      = pl_q.done;

    // R3: convert low lasts a single cycle
    p_conv_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !convert_n_o |=> convert_n_o);
    // R3: start-of-scan and convert never coincide
    p_sos_not_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sos_o |-> convert_n_o);
    // R4: scan clock follows every convert
    p_sclk_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !convert_n_o |=> scan_clk_o);
    // R7: done only together with a conversion
    p_done_with_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !convert_n_o);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int IVL_W  = 16,
    parameter int SCAN_W = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              ref_trig_i,
    input  logic              stop_i,
    input  logic              gate_i,
    input  logic              hold_i,
    input  logic              src_ext_i,
    input  logic              ext_scan_i,
    input  logic              tick_i,
    input  logic              pretrig_i,
    input  logic [IVL_W-1:0]  scan_ivl_i,
    input  logic [IVL_W-1:0]  samp_ivl_i,
    input  logic [CH_W-1:0]   last_chan_i,
    input  logic [SCAN_W-1:0] post_scans_i,
    output logic              sos_o,
    output logic              convert_n_o,
    output logic              scan_clk_o,
    output logic              done_o
);
    localparam logic [IVL_W-1:0] SAMP_FIRST = '0;

    typedef struct packed {
        logic            running;
        logic            in_scan;
        logic [CH_W-1:0] ch_left;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    scan_src_e src;
    logic      scan_tc, samp_tc, last_scan;
    logic      arm_ok, scan_req, sos_fire, conv_fire, scan_end, final_fire;

    assign src = scan_src_e'(src_ext_i);

    always_comb begin
        arm_ok     = arm_i && !ctl_q.running && !stop_i;
        scan_req   = ctl_q.running && ((src == SRC_EXT) ? ext_scan_i : scan_tc);
        sos_fire   = scan_req && !ctl_q.in_scan && gate_i && !hold_i && !stop_i;
        conv_fire  = samp_tc && !stop_i;
        scan_end   = conv_fire && (ctl_q.ch_left == '0);
        final_fire = scan_end && last_scan;

        ctl_d = ctl_q;
        if (stop_i) begin
            ctl_d.running = 1'b0;
            ctl_d.in_scan = 1'b0;
        end else begin
            if (arm_ok)
                ctl_d.running = 1'b1;
            if (sos_fire) begin
                ctl_d.in_scan = 1'b1;
                ctl_d.ch_left = last_chan_i;
            end
            if (conv_fire) begin
                if (ctl_q.ch_left == '0) ctl_d.in_scan = 1'b0;
                else                     ctl_d.ch_left = ctl_q.ch_left - 1'b1;
            end
            if (final_fire)
                ctl_d.running = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    ivl_counter #(.W(IVL_W)) u_scan_ivl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (arm_ok),
        .load_val_i (scan_ivl_i),
        .run_i      (ctl_q.running),
        .tick_i     (tick_i),
        .reload_i   (scan_ivl_i),
        .tc_o       (scan_tc)
    );

    ivl_counter #(.W(IVL_W)) u_samp_ivl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sos_fire),
        .load_val_i (SAMP_FIRST),
        .run_i      (ctl_q.in_scan),
        .tick_i     (tick_i),
        .reload_i   (samp_ivl_i),
        .tc_o       (samp_tc)
    );

    scan_tracker #(.W(SCAN_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (arm_ok),
        .pretrig_i  (pretrig_i),
        .post_i     (post_scans_i),
        .ref_i      (ref_trig_i && ctl_q.running),
        .scan_end_i (scan_end),
        .last_o     (last_scan)
    );

    pulse_gen u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .sos_fire_i   (sos_fire),
        .conv_fire_i  (conv_fire),
        .final_fire_i (final_fire),
        .sos_o        (sos_o),
        .convert_n_o  (convert_n_o),
        .scan_clk_o   (scan_clk_o),
        .done_o       (done_o)
    );

    // R9: stop silences every pulse from the next cycle
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (convert_n_o && !sos_o && !done_o));
    // R5: no start-of-scan from an idle sequencer
    p_idle_no_sos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.running |=> !sos_o);
    // R6: a closed gate or an active hold blocks start-of-scan
    p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i || hold_i) |=> !sos_o);
    // R7: the run is over after done
    p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ctl_q.running);

endmodule

// File: tb/sim_acq_sequencer.sv
`timescale 1ns/1ps
module sim_acq_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 0, ref_trig_i = 0, stop_i = 0, gate_i = 1, hold_i = 0;
    logic        src_ext_i = 0, ext_scan_i = 0, tick_i = 1, pretrig_i = 0;
    logic [15:0] scan_ivl_i = '0, samp_ivl_i = '0, post_scans_i = '0;
    logic [3:0]  last_chan_i = '0;
    logic        sos_o, convert_n_o, scan_clk_o, done_o;

    always #2.5 clk = ~clk;

    acq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .ref_trig_i(ref_trig_i),
        .stop_i(stop_i), .gate_i(gate_i), .hold_i(hold_i), .src_ext_i(src_ext_i),
        .ext_scan_i(ext_scan_i), .tick_i(tick_i), .pretrig_i(pretrig_i),
        .scan_ivl_i(scan_ivl_i), .samp_ivl_i(samp_ivl_i), .last_chan_i(last_chan_i),
        .post_scans_i(post_scans_i), .sos_o(sos_o), .convert_n_o(convert_n_o),
        .scan_clk_o(scan_clk_o), .done_o(done_o)
    );

    int    cyc = 0;
    int    compared = 0, mismatched = 0;
    int    exp_q[$];
    bit    mon_en = 0;
    string cur_req = "R11";

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: event key = cycle*4 + kind (0 sos, 1 convert, 2 scan clock, 3 done)
    always @(negedge clk) begin
        if (mon_en) begin
            for (int k = 0; k < 4; k++) begin
                bit hit;
                int key, e;
                case (k)
                    0: hit = sos_o;
                    1: hit = !convert_n_o;
                    2: hit = scan_clk_o;
                    default: hit = done_o;
                endcase
                if (hit) begin
                    key = cyc * 4 + k;
                    compared++;
                    if (exp_q.size() == 0) begin
                        mismatched++;
                        $display("FAIL %s: actual kind %0d at cycle %0d, expected no event",
                                 cur_req, k, cyc);
                    end else begin
                        e = exp_q.pop_front();
                        if (e != key) begin
                            mismatched++;
                            $display("FAIL %s: actual kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                                     cur_req, k, cyc, e % 4, e / 4);
                        end
                    end
                end
            end
        end
    end

    task automatic wait_to(input int x);
        while (cyc < x) @(negedge clk);
    endtask

    task automatic do_arm(output int a);
        arm_i = 1; a = cyc + 1;
        @(negedge clk);
        arm_i = 0;
    endtask

    task automatic pulse_at(input int x, input int which);
        wait_to(x);
        case (which)
            0: ext_scan_i = 1;
            1: ref_trig_i = 1;
            2: stop_i = 1;
            default: arm_i = 1;
        endcase
        @(negedge clk);
        ext_scan_i = 0; ref_trig_i = 0; stop_i = 0; arm_i = 0;
    endtask

    // driver: push expected events for the listed start-of-scan cycles
    task automatic gen(input int sl[$], input int p, input int c, input bit dn);
        foreach (sl[i]) begin
            exp_q.push_back(sl[i] * 4 + 0);
            for (int j = 0; j <= c; j++) begin
                int cv;
                cv = sl[i] + 1 + j * (p + 1);
                exp_q.push_back(cv * 4 + 1);
                exp_q.push_back((cv + 1) * 4 + 2);
                if (dn && i == sl.size() - 1 && j == c) exp_q.push_back(cv * 4 + 3);
            end
        end
        exp_q.sort();
    endtask

    task automatic drain(input string tag);
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (30) @(negedge clk);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL %s: actual %0d events missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic setup(input int s, input int p, input int c, input int post, input bit pre);
        scan_ivl_i = 16'(s); samp_ivl_i = 16'(p); last_chan_i = 4'(c);
        post_scans_i = 16'(post); pretrig_i = pre;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int a, sl[$];
        // R11: reset state
        repeat (3) @(negedge clk);
        compared++; if (convert_n_o !== 1'b1) begin mismatched++; $display("FAIL R11: convert_n actual %b expected 1", convert_n_o); end
        compared++; if (sos_o !== 1'b0) begin mismatched++; $display("FAIL R11: sos actual %b expected 0", sos_o); end
        compared++; if (scan_clk_o !== 1'b0) begin mismatched++; $display("FAIL R11: scan_clk actual %b expected 0", scan_clk_o); end
        compared++; if (done_o !== 1'b0) begin mismatched++; $display("FAIL R11: done actual %b expected 0", done_o); end
        rst_n = 1;
        repeat (3) @(negedge clk);
        mon_en = 1;

        // R1 R2 R3 R4 R7: three scans of three channels, second arm ignored
        cur_req = "R1 R2 R3 R4 R7";
        setup(10, 2, 2, 3, 0);
        do_arm(a);
        sl.delete(); for (int k = 0; k < 3; k++) sl.push_back(a + 11 + 11 * k);
        gen(sl, 2, 2, 1);
        pulse_at(a + 11, 3);
        drain(cur_req);

        // R7: post count 0 behaves as one scan, single channel
        cur_req = "R7";
        setup(4, 5, 0, 0, 0);
        do_arm(a);
        sl.delete(); sl.push_back(a + 5);
        gen(sl, 5, 0, 1);
        drain(cur_req);

        // R6: gate low around slot 1, hold high around slot 3
        cur_req = "R6";
        setup(12, 1, 3, 3, 0);
        do_arm(a);
        sl.delete(); sl.push_back(a + 13); sl.push_back(a + 39); sl.push_back(a + 65);
        gen(sl, 1, 3, 1);
        wait_to(a + 24); gate_i = 0;
        wait_to(a + 27); gate_i = 1;
        wait_to(a + 50); hold_i = 1;
        wait_to(a + 52); hold_i = 0;
        drain(cur_req);

        // R8: pretrigger, reference trigger between scan 2 and scan 3
        cur_req = "R8";
        setup(20, 3, 2, 2, 1);
        pulse_at(cyc + 2, 1);           // before arm: no effect
        do_arm(a);
        sl.delete(); for (int k = 0; k < 5; k++) sl.push_back(a + 21 + 21 * k);
        gen(sl, 3, 2, 1);
        pulse_at(a + 72, 1);
        drain(cur_req);
        pretrig_i = 0;

        // R9: stop between the second and third conversion of scan 0
        cur_req = "R9";
        setup(10, 3, 2, 5, 0);
        do_arm(a);
        exp_q.push_back((a + 11) * 4 + 0);
        exp_q.push_back((a + 12) * 4 + 1);
        exp_q.push_back((a + 13) * 4 + 2);
        exp_q.push_back((a + 16) * 4 + 1);
        exp_q.push_back((a + 17) * 4 + 2);
        pulse_at(a + 17, 2);
        drain(cur_req);

        // R5: external request while idle is ignored
        cur_req = "R5";
        src_ext_i = 1;
        pulse_at(cyc + 3, 0);
        drain(cur_req);

        // R5: external source, second request while busy is dropped
        setup(1000, 2, 1, 2, 0);
        do_arm(a);
        sl.delete(); sl.push_back(a + 6); sl.push_back(a + 21);
        gen(sl, 2, 1, 1);
        pulse_at(a + 5, 0);
        pulse_at(a + 7, 0);
        pulse_at(a + 20, 0);
        drain(cur_req);
        src_ext_i = 0;

        // R10: ticks withheld for 7 cycles after arm
        cur_req = "R10";
        setup(6, 1, 1, 2, 0);
        tick_i = 0;
        do_arm(a);
        sl.delete(); sl.push_back(a + 7 + 7); sl.push_back(a + 7 + 14);
        gen(sl, 1, 1, 1);
        wait_to(a + 7); tick_i = 1;
        drain(cur_req);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule